// File: doc/BRIEF.md
# Flash Page Load Buffer Controller

This block is the host-facing write front end of a byte-wide flash model with 128-byte pages. The host presents a write strobe with an address and a data byte. The block captures each byte in a page-sized staging buffer, and the bytes may arrive in any order. The address is split into a page number (upper bits) and an offset within the page (lower seven bits). All bytes of one load phase must target the page of the first byte. A byte aimed at another page is dropped and raises a sticky error flag.

The load phase stays open as long as strobes keep arriving. When a set number of clock cycles pass with no accepted byte, the block starts an internal program cycle. During that cycle `busy` is high and new strobes are ignored. When the cycle ends, all 128 bytes of the staged page are written into the behavioural array in one clock. Any byte that was not loaded is written as FFh. The staging buffer is then emptied.

The read port returns the committed array contents without a clock. Timeouts and the array size are parameters. A full-size device uses a 17-bit address, and the default is kept small so the behavioural array stays compact.

Top module: `flash_page_loader`

## Requirements
- R1: The page number is `wr_addr[ADDR_W-1:7]` and the byte offset within the page is `wr_addr[6:0]`. Bytes written to one page never change another page.
- R2: Bytes of a page may be loaded in any order. A repeated load of the same offset replaces the earlier byte, so the last load wins.
- R3: On commit, every offset of the page that was not loaded in the phase is written as FFh.
- R4: The load phase ends when LOAD_TIMEOUT_CYC consecutive clock edges pass after the last accepted byte with no further accepted byte. `busy` goes high at that edge. A byte accepted earlier restarts the count.
- R5: `busy` stays high for exactly PROG_CYC cycles. At the edge where it falls, all 128 bytes of the page are written into the array together, and `busy` cannot rise again in the next cycle.
- R6: While a phase is open, a byte whose page number differs from the phase's page is discarded. It does not restart the timeout and it sets `page_err`. `page_err` then stays 1 until reset.
- R7: Write strobes presented while `busy` is high have no effect on the array or on the next phase.
- R8: After each commit the staging buffer is empty. Offsets not loaded in the following phase are committed as FFh, not as bytes from an earlier phase.
- R9: After reset, `busy` and `page_err` are 0 and every array location reads FFh.
- R10: `rd_data` shows the committed array byte at `rd_addr` in the same cycle. Staged bytes are not visible until the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Byte-load strobe, sampled on each rising edge |
| wr_addr | input | ADDR_W | Byte address: page in upper bits, offset in bits 6:0 |
| wr_data | input | 8 | Byte to load |
| rd_addr | input | ADDR_W | Read address into the committed array |
| rd_data | output | 8 | Committed byte at `rd_addr` |
| busy | output | 1 | High while the internal program cycle runs |
| page_err | output | 1 | Sticky flag: a byte for a foreign page was discarded |

## Verification
The bench builds the block with a 9-bit address (four pages), a 6-cycle load timeout and a 10-cycle program cycle. With these values, a gap of one cycle less than the timeout, the exact edge where the phase closes, and the full length of the program window can all be reached in a few dozen cycles. A page mismatch, strobes issued during `busy`, and a second phase on a page that was already committed all fit within one short run. Because every page is small relative to the run, the bench can read all offsets of a committed page and confirm the FFh fill and the last-load-wins order.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef logic [7:0] byte_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pgw_state_t;

   localparam byte_t ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic done
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 2) begin : g_bad_limit
      $error("pgw_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign done = run && !restart && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || done) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4 / R5: the counter never passes its terminal value
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
   import pgw_pkg::*;
#(
   parameter int    PAGE_BYTES = 128,
   parameter int    OFF_W      = $clog2(PAGE_BYTES),
   parameter byte_t FILL       = ERASED_BYTE
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [OFF_W-1:0]            wr_off,
   input  byte_t                       wr_byte,
   input  logic                        clr,
   output logic [PAGE_BYTES-1:0][7:0]  page_img
);
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_size
      $error("pgw_page_buf: PAGE_BYTES must equal 2**OFF_W");
   end

   logic [PAGE_BYTES-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (clr) begin
         valid_q <= '0;
      end else if (we) begin
         valid_q[wr_off] <= 1'b1;
      end
   end

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      byte_t data_q;
      always_ff @(posedge clk) begin
         if (we && !clr && (wr_off == OFF_W'(i))) begin
            data_q <= wr_byte;
         end
      end
      assign page_img[i] = valid_q[i] ? data_q : FILL;
   end

   // R8: a clear leaves no staged byte behind
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (valid_q == '0));

   // R2: a write marks its slot as loaded
   p_write_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> valid_q[$past(wr_off)]);

endmodule

// File: rtl/pgw_array.sv
module pgw_array
   import pgw_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int PAGE_BYTES = 128,
   parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit,
   input  logic [ADDR_W-OFF_W-1:0]     commit_page,
   input  logic [PAGE_BYTES-1:0][7:0]  page_img,
   input  logic [ADDR_W-1:0]           rd_addr,
   output byte_t                       rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("pgw_array: ADDR_W must exceed the offset width");
   end

   byte_t mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= ERASED_BYTE;
         end
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            mem_q[{commit_page, OFF_W'(i)}] <= page_img[i];
         end
      end
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader
   import pgw_pkg::*;
#(
   parameter int    ADDR_W           = 11,
   parameter int    PAGE_BYTES       = 128,
   parameter int    LOAD_TIMEOUT_CYC = 300,
   parameter int    PROG_CYC         = 10000,
   parameter byte_t FILL_BYTE        = ERASED_BYTE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              page_err
);
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;

   if (PAGE_BYTES != 128) begin : g_bad_page
      $error("flash_page_loader: the page split assumes 128-byte pages");
   end
   if (LOAD_TIMEOUT_CYC < 2 || PROG_CYC < 2) begin : g_bad_time
      $error("flash_page_loader: timeouts must be at least 2 cycles");
   end

   pgw_state_t        state_q, state_d;
   logic [PAGE_W-1:0] page_q;
   logic              err_q;

   logic [PAGE_W-1:0] in_page;
   logic [OFF_W-1:0]  in_off;
   logic              same_page, buf_we, reject;
   logic              load_done, prog_done;
   logic [PAGE_BYTES-1:0][7:0] page_img;

   assign in_page   = wr_addr[ADDR_W-1:OFF_W];
   assign in_off    = wr_addr[OFF_W-1:0];
   assign same_page = (in_page == page_q);
   assign buf_we    = wr_stb && ((state_q == ST_IDLE) ||
                                 ((state_q == ST_LOAD) && same_page));
   assign reject    = wr_stb && (state_q == ST_LOAD) && !same_page;

   pgw_timer #(.LIMIT(LOAD_TIMEOUT_CYC)) u_load_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (buf_we),
      .run     (state_q == ST_LOAD),
      .done    (load_done)
   );

   pgw_timer #(.LIMIT(PROG_CYC)) u_prog_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_q != ST_PROG),
      .run     (state_q == ST_PROG),
      .done    (prog_done)
   );

   pgw_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .OFF_W      (OFF_W),
      .FILL       (FILL_BYTE)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (buf_we),
      .wr_off   (in_off),
      .wr_byte  (wr_data),
      .clr      (prog_done),
      .page_img (page_img)
   );

   pgw_array #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .OFF_W      (OFF_W)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (prog_done),
      .commit_page (page_q),
      .page_img    (page_img),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (buf_we)    state_d = ST_LOAD;
         ST_LOAD: if (load_done) state_d = ST_PROG;
         ST_PROG: if (prog_done) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         page_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && buf_we) page_q <= in_page;
         if (reject) err_q <= 1'b1;
      end
   end

   assign busy     = (state_q == ST_PROG);
   assign page_err = err_q;

   // R6: the error flag holds until reset
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |=> page_err);

   // R6: the flag only rises after a strobe
   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(page_err) |-> $past(wr_stb));

   // R7: nothing reaches the staging buffer during the program cycle
   p_busy_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);

   // R4: the program cycle never starts right after an accepted byte
   p_quiet_before_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!buf_we));

   // R5: a finished program cycle is followed by an idle cycle
   p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> !busy);

endmodule

// File: tb/flash_page_loader_tb.sv
module flash_page_loader_tb;
   localparam int AW = 9;
   localparam int TO = 6;
   localparam int PC = 10;
   localparam int PB = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy, page_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flash_page_loader #(
      .ADDR_W(AW), .PAGE_BYTES(PB), .LOAD_TIMEOUT_CYC(TO), .PROG_CYC(PC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .page_err(page_err)
   );

   // behavioural reference model
   int         mst, mcnt, mpc, mpage;
   bit         merr;
   logic [7:0] mmem [2**AW];
   logic [7:0] mbuf [PB];
   bit         mval [PB];

   always @(posedge clk) begin
      int pg;
      int off;
      pg  = int'(wr_addr) / PB;
      off = int'(wr_addr) % PB;
      if (!rst_n) begin
         mst = 0; mcnt = 0; mpc = 0; mpage = 0; merr = 1'b0;
         foreach (mmem[i]) mmem[i] = 8'hFF;
         foreach (mval[i]) mval[i] = 1'b0;
      end else begin
         case (mst)
            0: if (wr_stb) begin
                  mbuf[off] = wr_data; mval[off] = 1'b1;
                  mpage = pg; mcnt = 0; mst = 1;
               end
            1: if (wr_stb && pg == mpage) begin
                  mbuf[off] = wr_data; mval[off] = 1'b1; mcnt = 0;
               end else begin
                  if (wr_stb) merr = 1'b1;
                  if (mcnt == TO - 1) begin mst = 2; mpc = 0; end
                  else mcnt++;
               end
            default: if (mpc == PC - 1) begin
                  for (int i = 0; i < PB; i++) begin
                     mmem[mpage*PB + i] = mval[i] ? mbuf[i] : 8'hFF;
                     mval[i] = 1'b0;
                  end
                  mst = 0;
               end else mpc++;
         endcase
      end
   end

   task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check8("R4/R5 busy vs model", {7'd0, busy}, {7'd0, mst == 2});
         check8("R6 page_err vs model", {7'd0, page_err}, {7'd0, merr});
         check8("R10 rd_data vs model", rd_data, mmem[rd_addr]);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finish_run();
   end

   function automatic logic [AW-1:0] adr(int page, int off);
      return AW'(page * PB + off);
   endfunction

   task automatic load(int page, int off, logic [7:0] d);
      @(posedge clk); #1;
      wr_stb = 1'b1; wr_addr = adr(page, off); wr_data = d;
   endtask

   task automatic stb_off();
      @(posedge clk); #1;
      wr_stb = 1'b0;
   endtask

   task automatic read_chk(string req, int page, int off, logic [7:0] exp);
      @(posedge clk); #1;
      rd_addr = adr(page, off);
      @(negedge clk);
      check8(req, rd_data, exp);
   endtask

   task automatic settle();
      repeat (TO + PC + 3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset state
      @(negedge clk);
      check8("R9 busy after reset", {7'd0, busy}, 8'd0);
      check8("R9 page_err after reset", {7'd0, page_err}, 8'd0);
      read_chk("R9 erased array", 2, 17, 8'hFF);

      // R2 / R3 / R4 / R5 / R10: out-of-order page load with overwrite
      load(1, 5, 8'hA5);
      load(1, 0, 8'h11);
      load(1, 127, 8'h7E);
      load(1, 5, 8'hC3);
      stb_off();                      // last byte taken at this edge
      rd_addr = adr(1, 5);
      repeat (TO - 1) @(posedge clk);
      @(negedge clk);
      check8("R4 busy still low before timeout", {7'd0, busy}, 8'd0);
      @(posedge clk); @(negedge clk);
      check8("R4 busy high at timeout", {7'd0, busy}, 8'd1);
      check8("R10 staged byte invisible while busy", rd_data, 8'hFF);
      repeat (PC - 1) @(posedge clk);
      @(negedge clk);
      check8("R5 busy held for program window", {7'd0, busy}, 8'd1);
      @(posedge clk); @(negedge clk);
      check8("R5 busy released after window", {7'd0, busy}, 8'd0);
      check8("R5 page committed at busy fall", rd_data, 8'hC3);
      read_chk("R2 last load wins", 1, 5, 8'hC3);
      read_chk("R2 offset 0", 1, 0, 8'h11);
      read_chk("R1 offset 127", 1, 127, 8'h7E);
      read_chk("R3 unloaded offset 1", 1, 1, 8'hFF);
      read_chk("R3 unloaded offset 64", 1, 64, 8'hFF);
      read_chk("R1 neighbour page untouched", 0, 5, 8'hFF);

      // R6: foreign page rejected, flag sticky
      load(2, 3, 8'h33);
      load(3, 4, 8'h44);
      load(2, 9, 8'h99);
      stb_off();
      @(negedge clk);
      check8("R6 flag set on foreign page", {7'd0, page_err}, 8'd1);
      settle();
      read_chk("R6 rejected byte not written", 3, 4, 8'hFF);
      read_chk("R6 same-page byte kept", 2, 3, 8'h33);
      read_chk("R6 later same-page byte kept", 2, 9, 8'h99);
      @(negedge clk);
      check8("R6 flag still set", {7'd0, page_err}, 8'd1);

      // R7: strobes during busy are ignored
      load(0, 1, 8'h21);
      stb_off();
      repeat (TO + 1) @(posedge clk);
      @(negedge clk);
      check8("R7 program cycle running", {7'd0, busy}, 8'd1);
      load(0, 2, 8'h22);
      load(1, 0, 8'h5A);
      stb_off();
      settle();
      @(negedge clk);
      check8("R7 no new phase from busy strobes", {7'd0, busy}, 8'd0);
      read_chk("R7 busy strobe dropped", 0, 2, 8'hFF);
      read_chk("R7 other page unchanged", 1, 0, 8'h11);
      read_chk("R7 committed byte", 0, 1, 8'h21);

      // R4: a byte one cycle inside the timeout extends the phase
      load(3, 0, 8'h01);
      stb_off();
      repeat (TO - 2) @(posedge clk);
      @(negedge clk);
      check8("R4 phase open before late byte", {7'd0, busy}, 8'd0);
      load(3, 1, 8'h02);
      @(negedge clk);
      check8("R4 late byte keeps phase open", {7'd0, busy}, 8'd0);
      stb_off();
      settle();
      read_chk("R4 first byte committed", 3, 0, 8'h01);
      read_chk("R4 late byte committed", 3, 1, 8'h02);

      // R8: next phase starts from an empty buffer
      load(1, 64, 8'h64);
      stb_off();
      settle();
      read_chk("R8 new byte", 1, 64, 8'h64);
      read_chk("R8 old byte replaced by fill", 1, 5, 8'hFF);
      read_chk("R8 old offset 0 replaced by fill", 1, 0, 8'hFF);

      // R6 / R9: reset clears the flag and erases the array
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check8("R6 flag cleared by reset", {7'd0, page_err}, 8'd0);
      read_chk("R9 array erased by reset", 3, 0, 8'hFF);

      finish_run();
   end
endmodule